// File: doc/BRIEF.md
# Sleep Mode Power Controller

This block sits between the command path of a synchronous memory and its power domain and sequences a low-power sleep state. A sleep request arrives on an input that has no timing relation to the clock. The block resynchronizes it, spends a fixed number of cycles entering sleep, holds the sleep indication for the power domain while the request stays high, and spends a fixed number of cycles recovering once the request is withdrawn. While it is not fully awake it blocks every chip-enable command, so the stored contents cannot be disturbed during sleep.

When entry begins, the block emits a one-cycle flush pulse. The command path uses this pulse to discard any access still in flight, because such an access is not guaranteed to complete. The exit phase covers both the wake-up latency and the recovery window in which no chip enable may be active. A chip enable presented during entry or during that window is refused and reported on a protocol-error output one cycle later.

Top module: `sleep_ctrl`

## Requirements
- R1: After reset the controller is awake: `sleep_active`, `pend_flush` and `proto_err` are 0, and `access_ok` equals `acc_sel`.
- R2: `sleep_req` passes through SYNC_STAGES (default 2) flip-flops. The controller leaves the awake state on the rising edge that follows the edge at which the last synchronizer stage captures a 1, which is the third rising edge after a request that is stable before an edge.
- R3: The entering phase lasts ENTRY_CYCLES (default 2) cycles. `sleep_active` is 1 only in the asleep state, so it rises ENTRY_CYCLES edges after entry begins.
- R4: `pend_flush` is a one-cycle pulse in the first cycle of the entering phase and is 0 at all other times.
- R5: After `sleep_req` is released, `sleep_active` falls on the third rising edge. The exiting phase then lasts max(EXIT_CYCLES, RECOVER_CYCLES) cycles (default 2), after which the controller is awake again.
- R6: `access_ok` is 1 exactly when `acc_sel` is 1 and the controller is awake. Commands are blocked while entering, asleep and exiting.
- R7: `proto_err` is 1 in the cycle after a rising edge at which `acc_sel` was 1 while the controller was entering or exiting. An active `acc_sel` while asleep raises no error.
- R8: A request that reappears during the exiting phase does not shorten that phase. The controller completes recovery, is awake for one cycle (commands accepted), and then begins a new entry with a flush pulse.
- R9: A request pulse that does not span a rising clock edge has no effect: the controller stays awake, `access_ok` keeps following `acc_sel`, and no flush pulse occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_req | input | 1 | Sleep request, asynchronous to clk |
| acc_sel | input | 1 | Chip enable of the incoming access command |
| sleep_active | output | 1 | High while the memory is in the sleep state |
| access_ok | output | 1 | Qualified chip enable passed to the command path |
| pend_flush | output | 1 | One-cycle pulse that discards pending accesses at entry |
| proto_err | output | 1 | Chip enable seen during entry or recovery |

## Verification
Two functions can coincide. Blocking a command and raising the protocol error can both happen at the start of entry or during recovery. A request can also come back while recovery is still counting down. The directed scenarios hold `acc_sel` high across both edges of entry and exit. Each cycle is checked at the exact edge the requirements predict: `access_ok` must drop in the same cycle as the flush pulse, and `proto_err` must follow one cycle later. A request that is re-asserted during exiting is checked to produce one awake cycle with accepted commands before the new flush pulse.

// File: rtl/sleep_pkg.sv
package sleep_pkg;

   typedef enum logic [1:0] {
      SLP_AWAKE    = 2'd0,
      SLP_ENTERING = 2'd1,
      SLP_ASLEEP   = 2'd2,
      SLP_EXITING  = 2'd3
   } slp_state_e;

   function automatic int unsigned imax(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

   function automatic int unsigned cnt_bits(input int unsigned top);
      return (top > 1) ? $clog2(top) : 1;
   endfunction

endpackage

// File: rtl/sleep_sync.sv
module sleep_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_async,
   output logic q_sync
);

   generate
      if (STAGES == 0) begin : g_bypass
         assign q_sync = d_async;
      end else begin : g_chain
         logic [STAGES-1:0] chain_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= {chain_q[STAGES-2 >= 0 ? STAGES-2 : 0 : 0], d_async};
         end
         assign q_sync = chain_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/sleep_seq.sv
module sleep_seq
   import sleep_pkg::*;
#(
   parameter int unsigned ENTRY_CYCLES = 2,
   parameter int unsigned EXIT_LEN     = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       req_s,
   output slp_state_e state,
   output logic       flush
);

   localparam int unsigned MAXC  = imax(ENTRY_CYCLES, EXIT_LEN);
   localparam int unsigned CNT_W = cnt_bits(MAXC);
   localparam logic [CNT_W-1:0] ENT_LOAD = CNT_W'(ENTRY_CYCLES - 1);
   localparam logic [CNT_W-1:0] EXT_LOAD = CNT_W'(EXIT_LEN - 1);

   slp_state_e       state_q;
   logic [CNT_W-1:0] cnt_q;
   logic             flush_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SLP_AWAKE;
         cnt_q   <= '0;
         flush_q <= 1'b0;
      end else begin
         flush_q <= 1'b0;
         case (state_q)
            SLP_AWAKE: begin
               if (req_s) begin
                  state_q <= SLP_ENTERING;
                  cnt_q   <= ENT_LOAD;
                  flush_q <= 1'b1;
               end
            end
            SLP_ENTERING: begin
               if (cnt_q == '0) state_q <= SLP_ASLEEP;
               else             cnt_q   <= cnt_q - 1'b1;
            end
            SLP_ASLEEP: begin
               if (!req_s) begin
                  state_q <= SLP_EXITING;
                  cnt_q   <= EXT_LOAD;
               end
            end
            SLP_EXITING: begin
               if (cnt_q == '0) state_q <= SLP_AWAKE;
               else             cnt_q   <= cnt_q - 1'b1;
            end
            default: state_q <= SLP_AWAKE;
         endcase
      end
   end

   assign state = state_q;
   assign flush = flush_q;

endmodule

// File: rtl/sleep_gate.sv
module sleep_gate
   import sleep_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  slp_state_e state,
   input  logic       acc_sel,
   output logic       access_ok,
   output logic       proto_err
);

   logic in_window;
   logic err_q;

   assign in_window = (state == SLP_ENTERING) || (state == SLP_EXITING);
   assign access_ok = acc_sel && (state == SLP_AWAKE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) err_q <= 1'b0;
      else        err_q <= acc_sel && in_window;
   end

   assign proto_err = err_q;

endmodule

// File: rtl/sleep_ctrl.sv
module sleep_ctrl
   import sleep_pkg::*;
#(
   parameter int unsigned SYNC_STAGES    = 2,
   parameter int unsigned ENTRY_CYCLES   = 2,
   parameter int unsigned EXIT_CYCLES    = 2,
   parameter int unsigned RECOVER_CYCLES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sleep_req,
   input  logic acc_sel,
   output logic sleep_active,
   output logic access_ok,
   output logic pend_flush,
   output logic proto_err
);

   localparam int unsigned EXIT_LEN = imax(EXIT_CYCLES, RECOVER_CYCLES);

   generate
      if (ENTRY_CYCLES < 1) begin : g_bad_entry
         $error("sleep_ctrl: ENTRY_CYCLES must be at least 1");
      end
      if (EXIT_LEN < 1) begin : g_bad_exit
         $error("sleep_ctrl: exit or recovery length must be at least 1");
      end
      if (SYNC_STAGES == 1) begin : g_bad_sync
         $error("sleep_ctrl: SYNC_STAGES must be 0 or at least 2");
      end
   endgenerate

   logic       req_s;
   slp_state_e state_q;

   sleep_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async (sleep_req),
      .q_sync  (req_s)
   );

   sleep_seq #(.ENTRY_CYCLES(ENTRY_CYCLES), .EXIT_LEN(EXIT_LEN)) u_seq (
      .clk   (clk),
      .rst_n (rst_n),
      .req_s (req_s),
      .state (state_q),
      .flush (pend_flush)
   );

   sleep_gate u_gate (
      .clk       (clk),
      .rst_n     (rst_n),
      .state     (state_q),
      .acc_sel   (acc_sel),
      .access_ok (access_ok),
      .proto_err (proto_err)
   );

   assign sleep_active = (state_q == SLP_ASLEEP);

endmodule

// File: rtl/sleep_ctrl_chk.sv
module sleep_ctrl_chk
   import sleep_pkg::*;
#(
   parameter int unsigned ENTRY_CYCLES = 2,
   parameter int unsigned EXIT_LEN     = 2
) (
   input logic       clk,
   input logic       rst_n,
   input logic       acc_sel,
   input logic       access_ok,
   input logic       sleep_active,
   input logic       pend_flush,
   input logic       proto_err,
   input slp_state_e state
);

   int unsigned ent_run;
   int unsigned ext_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ent_run <= 0;
         ext_run <= 0;
      end else begin
         ent_run <= (state == SLP_ENTERING) ? ent_run + 1 : 0;
         ext_run <= (state == SLP_EXITING)  ? ext_run + 1 : 0;
      end
   end

   assert_entry_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (state == SLP_ENTERING) |-> (ent_run < ENTRY_CYCLES));

   assert_rise_after_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sleep_active) |-> ($past(state) == SLP_ENTERING));

   assert_flush_from_awake_R4: assert property (@(posedge clk) disable iff (!rst_n)
      pend_flush |-> ($past(state) == SLP_AWAKE));

   assert_flush_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
      pend_flush |=> !pend_flush);

   assert_exit_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (state == SLP_EXITING) |-> (ext_run < EXIT_LEN));

   assert_fall_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sleep_active) |-> !access_ok);

   assert_ok_needs_sel_R6: assert property (@(posedge clk) disable iff (!rst_n)
      access_ok |-> acc_sel);

   assert_asleep_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
      sleep_active |-> !access_ok);

   assert_err_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
      proto_err |-> $past(acc_sel));

endmodule

bind sleep_ctrl sleep_ctrl_chk #(
   .ENTRY_CYCLES (ENTRY_CYCLES),
   .EXIT_LEN     (EXIT_LEN)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .acc_sel      (acc_sel),
   .access_ok    (access_ok),
   .sleep_active (sleep_active),
   .pend_flush   (pend_flush),
   .proto_err    (proto_err),
   .state        (state_q)
);

// File: tb/test_sleep_ctrl.sv
`timescale 1ns/100ps
module test_sleep_ctrl;

   logic clk;
   logic rst_n;
   logic sleep_req;
   logic acc_sel;
   logic sleep_active;
   logic access_ok;
   logic pend_flush;
   logic proto_err;

   int checks;
   int errors;

   sleep_ctrl i_sleep_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .sleep_req    (sleep_req),
      .acc_sel      (acc_sel),
      .sleep_active (sleep_active),
      .access_ok    (access_ok),
      .pend_flush   (pend_flush),
      .proto_err    (proto_err)
   );

   initial begin
      clk = 1'b0;
      forever #2.5 clk = ~clk;
   end

   initial begin
      #(200000 * 5);
      errors++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic chk(input string req, input string what, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%b expected=%b at %0t", req, what, act, exp, $time);
      end
   endtask

   task automatic t_reset;
      rst_n = 1'b0; sleep_req = 1'b0; acc_sel = 1'b1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      step(1);
      chk("R1", "sleep_active", sleep_active, 1'b0);
      chk("R1", "pend_flush",   pend_flush,   1'b0);
      chk("R1", "proto_err",    proto_err,    1'b0);
      chk("R1", "access_ok",    access_ok,    1'b1);
   endtask

   task automatic t_entry;
      @(negedge clk);
      sleep_req = 1'b1; acc_sel = 1'b1;
      step(2);
      chk("R2", "access_ok before entry", access_ok, 1'b1);
      chk("R2", "pend_flush before entry", pend_flush, 1'b0);
      step(1);
      chk("R4", "pend_flush first entering cycle", pend_flush, 1'b1);
      chk("R6", "access_ok while entering", access_ok, 1'b0);
      chk("R7", "proto_err not yet", proto_err, 1'b0);
      step(1);
      chk("R4", "pend_flush second cycle", pend_flush, 1'b0);
      chk("R3", "sleep_active still entering", sleep_active, 1'b0);
      chk("R7", "proto_err entering", proto_err, 1'b1);
      step(1);
      chk("R3", "sleep_active asleep", sleep_active, 1'b1);
      chk("R7", "proto_err last entering", proto_err, 1'b1);
      step(1);
      chk("R7", "proto_err asleep", proto_err, 1'b0);
      chk("R6", "access_ok asleep", access_ok, 1'b0);
   endtask

   task automatic t_exit;
      @(negedge clk);
      sleep_req = 1'b0; acc_sel = 1'b1;
      step(2);
      chk("R5", "sleep_active held", sleep_active, 1'b1);
      chk("R7", "no error asleep", proto_err, 1'b0);
      step(1);
      chk("R5", "sleep_active dropped", sleep_active, 1'b0);
      chk("R6", "access_ok exiting", access_ok, 1'b0);
      chk("R7", "proto_err not yet", proto_err, 1'b0);
      step(1);
      chk("R5", "access_ok recovery", access_ok, 1'b0);
      chk("R7", "proto_err recovery", proto_err, 1'b1);
      step(1);
      chk("R5", "access_ok awake again", access_ok, 1'b1);
      chk("R7", "proto_err last recovery", proto_err, 1'b1);
      step(1);
      chk("R7", "proto_err clear", proto_err, 1'b0);
   endtask

   task automatic t_reentry;
      @(negedge clk);
      sleep_req = 1'b1; acc_sel = 1'b0;
      step(5);
      chk("R8", "asleep before release", sleep_active, 1'b1);
      @(negedge clk);
      sleep_req = 1'b0; acc_sel = 1'b1;
      step(3);
      chk("R8", "exiting started", sleep_active, 1'b0);
      @(negedge clk);
      sleep_req = 1'b1;
      step(1);
      chk("R8", "still recovering", access_ok, 1'b0);
      step(1);
      chk("R8", "one awake cycle", access_ok, 1'b1);
      chk("R8", "no flush yet", pend_flush, 1'b0);
      step(1);
      chk("R8", "new entry flush", pend_flush, 1'b1);
      chk("R8", "blocked on new entry", access_ok, 1'b0);
      step(2);
      chk("R8", "asleep again", sleep_active, 1'b1);
      @(negedge clk);
      sleep_req = 1'b0; acc_sel = 1'b0;
      step(6);
      acc_sel = 1'b1;
      #0.5;
      chk("R8", "awake after cleanup", access_ok, 1'b1);
   endtask

   task automatic t_glitch;
      @(negedge clk);
      acc_sel = 1'b1;
      sleep_req = 1'b1;
      #1 sleep_req = 1'b0;
      for (int i = 0; i < 6; i++) begin
         step(1);
         chk("R9", "no flush", pend_flush, 1'b0);
         chk("R9", "access_ok kept", access_ok, 1'b1);
         chk("R9", "no sleep", sleep_active, 1'b0);
      end
   endtask

   initial begin
      checks = 0;
      errors = 0;
      t_reset;
      t_entry;
      t_exit;
      t_reentry;
      t_glitch;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule